// File: doc/BRIEF.md
# SPI FIFO Flag and Request Controller

This block sits between the serial shift engine of an SPI peripheral and the CPU/DMA side. It holds an eight-byte (64-bit) receive FIFO, filled by the shift engine and drained by the host, and an eight-byte (64-bit) transmit FIFO, filled by the host and drained by the shift engine. From the two fill levels it derives registered status flags. It turns those flags into DMA requests, or into CPU interrupt requests when DMA is off for that direction. Two watermark flags, transmit nearly-empty and receive nearly-full, can also raise the interrupt through their own enables.

A byte-wide control register turns FIFO mode on, picks the transmit watermark and holds the two watermark interrupt enables. The register only accepts a write whose FIFO-enable bit is 1, so FIFO mode cannot be switched off again after reset. The per-direction DMA and interrupt enables belong to the surrounding SPI control logic and come in as plain inputs.

Top module: `spi_fifo_flags`

## Requirements
- R1: After reset, the control register reads 0x00, rxEmpty is 1, txFull is 0, txNearEmpty is 1, rxNearFull is 0, both overflow bits are 0, both DMA requests are 0, irq is 0 and both pop data outputs are 0.
- R2: Control register fields: bit 0 fifoEn, bit 1 txNearIe, bit 2 rxFullIe, bit 3 txMarkSel. Bits 7:4 always read 0. A write with regWdata[0] = 0 leaves the register unchanged, and a write with regWdata[0] = 1 loads bits 3:0. regRdata shows the register contents in the cycle after the write edge.
- R3: While fifoEn is 0, every push and pop is ignored and the FIFO levels stay unchanged. Both DMA requests and irq are 0.
- R4: Each FIFO holds up to 8 bytes in first-in first-out order. A pop places the oldest byte on the pop data output after the clock edge that takes the pop. That output holds its value until the next pop.
- R5: rxEmpty is 1 exactly when the receive FIFO holds no byte. txFull is 1 exactly when the transmit FIFO holds 8 bytes. All flags, requests and irq are registered and reflect a push or pop from the clock edge that takes it.
- R6: txNearEmpty is 1 when the transmit FIFO holds at most 2 bytes (16 bits) with txMarkSel = 0, or at most 4 bytes (32 bits) with txMarkSel = 1.
- R7: rxNearFull is 1 when the receive FIFO holds 6 or more bytes (48 bits).
- R8: rxDmaReq is 1 while fifoEn and rxDmaEn are 1 and rxEmpty is 0. txDmaReq is 1 while fifoEn and txDmaEn are 1 and txFull is 0.
- R9: With rxDmaEn = 0 and rxIntEn = 1, a non-empty receive FIFO raises irq. With txDmaEn = 0 and txIntEn = 1, a transmit FIFO that is not full raises irq.
- R10: txNearIe = 1 with txNearEmpty = 1, or rxFullIe = 1 with rxNearFull = 1, raises irq whatever the DMA enables are.
- R11: A push to a full FIFO is dropped and sets that direction's sticky overflow bit, which only reset clears. A pop from an empty FIFO loads 0 onto the pop data output and leaves the level unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Control register write strobe |
| regWdata | input | 8 | Control register write data |
| regRdata | output | 8 | Control register read data |
| rxDmaEn | input | 1 | Receive DMA enable |
| txDmaEn | input | 1 | Transmit DMA enable |
| rxIntEn | input | 1 | Receive data interrupt enable |
| txIntEn | input | 1 | Transmit space interrupt enable |
| engRxPush | input | 1 | Shift engine pushes a received byte |
| engRxData | input | 8 | Received byte |
| hostRxPop | input | 1 | Host pops a received byte |
| hostRxData | output | 8 | Last byte popped from the receive FIFO |
| hostTxPush | input | 1 | Host pushes a byte to send |
| hostTxData | input | 8 | Byte to send |
| engTxPop | input | 1 | Shift engine pops a byte to send |
| engTxData | output | 8 | Last byte popped from the transmit FIFO |
| rxEmpty | output | 1 | Receive FIFO empty flag |
| txFull | output | 1 | Transmit FIFO full flag |
| txNearEmpty | output | 1 | Transmit watermark flag |
| rxNearFull | output | 1 | Receive watermark flag |
| rxOverflow | output | 1 | Sticky receive overflow |
| txOverflow | output | 1 | Sticky transmit overflow |
| rxDmaReq | output | 1 | Receive DMA request |
| txDmaReq | output | 1 | Transmit DMA request |
| irq | output | 1 | CPU interrupt request |

## Verification
Random traffic runs in phases that lean toward filling or toward draining. This drives both FIFOs through empty, every watermark crossing and full. It separates off-by-one threshold errors from correct compares, and it catches pointer wrap faults that a single short burst would miss. Simultaneous push and pop at the full and empty boundaries check that acceptance depends on the level before the edge. Random changes of the DMA and interrupt enables show whether each data condition reaches the DMA request or the interrupt, and never both. Directed sequences cover disabled mode, gated register writes, both watermark selections, overflow and the pop from an empty FIFO.

// File: rtl/spiff_pkg.sv
package spiff_pkg;

  // Control register fields, stored in bits 3:0
  typedef struct packed {
    logic txMarkSel;
    logic rxFullIe;
    logic txNearIe;
    logic fifoEn;
  } ctrl_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic rxPush;
    logic rxPop;
    logic rxPopZero;
    logic txPush;
    logic txPop;
    logic txPopZero;
  } strobe_t;

endpackage

// File: rtl/spiff_fifo.sv
module spiff_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushEn,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popEn,
  input  logic              popZero,
  output logic [DATA_W-1:0] popData,
  output logic [CNT_W-1:0]  level,
  output logic [CNT_W-1:0]  levelNext
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign levelNext = level + CNT_W'(pushEn) - CNT_W'(popEn);

  always_ff @(posedge clk) begin
    if (pushEn) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      level   <= '0;
      popData <= '0;
    end else begin
      level <= levelNext;
      if (pushEn) wrPtr <= bump(wrPtr);
      if (popEn) begin
        rdPtr   <= bump(rdPtr);
        popData <= mem[rdPtr];
      end else if (popZero) begin
        popData <= '0;
      end
    end
  end

  // R4
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    level <= CNT_W'(DEPTH));
  // R11
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    pushEn |-> level != CNT_W'(DEPTH));
  // R11
  empty_pop_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    popZero |-> level == '0 && !popEn);
  // R11
  empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    popZero && !pushEn |=> level == '0);

endmodule

// File: rtl/spiff_datapath.sv
module spiff_datapath
  import spiff_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] engRxData,
  output logic [DATA_W-1:0] hostRxData,
  input  logic [DATA_W-1:0] hostTxData,
  output logic [DATA_W-1:0] engTxData,
  output logic [CNT_W-1:0]  rxLevel,
  output logic [CNT_W-1:0]  rxLevelNext,
  output logic [CNT_W-1:0]  txLevel,
  output logic [CNT_W-1:0]  txLevelNext
);

  spiff_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) rxFifo (
    .clk       (clk),
    .rstN      (rstN),
    .pushEn    (strobe.rxPush),
    .pushData  (engRxData),
    .popEn     (strobe.rxPop),
    .popZero   (strobe.rxPopZero),
    .popData   (hostRxData),
    .level     (rxLevel),
    .levelNext (rxLevelNext)
  );

  spiff_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) txFifo (
    .clk       (clk),
    .rstN      (rstN),
    .pushEn    (strobe.txPush),
    .pushData  (hostTxData),
    .popEn     (strobe.txPop),
    .popZero   (strobe.txPopZero),
    .popData   (engTxData),
    .level     (txLevel),
    .levelNext (txLevelNext)
  );

endmodule

// File: rtl/spiff_ctrl.sv
module spiff_ctrl
  import spiff_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int DEPTH        = 8,
  parameter int TX_LO_BITS   = 16,
  parameter int TX_HI_BITS   = 32,
  parameter int RX_FULL_BITS = 48,
  localparam int CNT_W       = $clog2(DEPTH + 1),
  localparam int TX_LO_ENT   = TX_LO_BITS / DATA_W,
  localparam int TX_HI_ENT   = TX_HI_BITS / DATA_W,
  localparam int RX_FULL_ENT = RX_FULL_BITS / DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [7:0]       regWdata,
  output logic [7:0]       regRdata,
  input  logic             rxDmaEn,
  input  logic             txDmaEn,
  input  logic             rxIntEn,
  input  logic             txIntEn,
  input  logic             engRxPush,
  input  logic             hostRxPop,
  input  logic             hostTxPush,
  input  logic             engTxPop,
  input  logic [CNT_W-1:0] rxLevel,
  input  logic [CNT_W-1:0] rxLevelNext,
  input  logic [CNT_W-1:0] txLevel,
  input  logic [CNT_W-1:0] txLevelNext,
  output strobe_t          strobe,
  output logic             rxEmpty,
  output logic             txFull,
  output logic             txNearEmpty,
  output logic             rxNearFull,
  output logic             rxOverflow,
  output logic             txOverflow,
  output logic             rxDmaReq,
  output logic             txDmaReq,
  output logic             irq
);

  ctrl_t ctrlQ;
  logic  rxFullNow, rxEmptyNow, txFullNow, txEmptyNow;
  logic  rxEmptyN, txFullN, txNearN, rxNearN;
  logic [CNT_W-1:0] txMark;

  assign regRdata = {4'b0000, ctrlQ};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      ctrlQ <= '0;
    else if (regWe && regWdata[0])  ctrlQ <= ctrl_t'(regWdata[3:0]);
  end

  assign rxFullNow  = rxLevel == CNT_W'(DEPTH);
  assign rxEmptyNow = rxLevel == '0;
  assign txFullNow  = txLevel == CNT_W'(DEPTH);
  assign txEmptyNow = txLevel == '0;

  always_comb begin
    strobe           = '0;
    strobe.rxPush    = ctrlQ.fifoEn && engRxPush && !rxFullNow;
    strobe.rxPop     = ctrlQ.fifoEn && hostRxPop && !rxEmptyNow;
    strobe.rxPopZero = ctrlQ.fifoEn && hostRxPop && rxEmptyNow;
    strobe.txPush    = ctrlQ.fifoEn && hostTxPush && !txFullNow;
    strobe.txPop     = ctrlQ.fifoEn && engTxPop && !txEmptyNow;
    strobe.txPopZero = ctrlQ.fifoEn && engTxPop && txEmptyNow;
  end

  assign txMark   = ctrlQ.txMarkSel ? CNT_W'(TX_HI_ENT) : CNT_W'(TX_LO_ENT);
  assign rxEmptyN = rxLevelNext == '0;
  assign txFullN  = txLevelNext == CNT_W'(DEPTH);
  assign txNearN  = txLevelNext <= txMark;
  assign rxNearN  = rxLevelNext >= CNT_W'(RX_FULL_ENT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxEmpty     <= 1'b1;
      txFull      <= 1'b0;
      txNearEmpty <= 1'b1;
      rxNearFull  <= 1'b0;
      rxOverflow  <= 1'b0;
      txOverflow  <= 1'b0;
      rxDmaReq    <= 1'b0;
      txDmaReq    <= 1'b0;
      irq         <= 1'b0;
    end else begin
      rxEmpty     <= rxEmptyN;
      txFull      <= txFullN;
      txNearEmpty <= txNearN;
      rxNearFull  <= rxNearN;
      if (ctrlQ.fifoEn && engRxPush && rxFullNow)  rxOverflow <= 1'b1;
      if (ctrlQ.fifoEn && hostTxPush && txFullNow) txOverflow <= 1'b1;
      rxDmaReq <= ctrlQ.fifoEn && rxDmaEn && !rxEmptyN;
      txDmaReq <= ctrlQ.fifoEn && txDmaEn && !txFullN;
      irq      <= ctrlQ.fifoEn && (
                    (!rxDmaEn && rxIntEn && !rxEmptyN) ||
                    (!txDmaEn && txIntEn && !txFullN) ||
                    (ctrlQ.txNearIe && txNearN) ||
                    (ctrlQ.rxFullIe && rxNearN));
    end
  end

  // R2
  write_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe && !regWdata[0] |=> $stable(ctrlQ));
  // R3
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ.fifoEn |-> !irq && !rxDmaReq && !txDmaReq);
  // R8
  rx_dma_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDmaReq |-> !rxEmpty);
  // R8
  tx_dma_chk: assert property (@(posedge clk) disable iff (!rstN)
    txDmaReq |-> !txFull);
  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxOverflow && txOverflow |=> rxOverflow && txOverflow);
  // R5
  rx_flag_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxEmpty |-> !rxNearFull);
  // R5
  tx_flag_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    txFull |-> !txNearEmpty);

endmodule

// File: rtl/spi_fifo_flags.sv
module spi_fifo_flags
  import spiff_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int DEPTH        = 8,
  parameter int TX_LO_BITS   = 16,
  parameter int TX_HI_BITS   = 32,
  parameter int RX_FULL_BITS = 48,
  localparam int CNT_W       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic              rxDmaEn,
  input  logic              txDmaEn,
  input  logic              rxIntEn,
  input  logic              txIntEn,
  input  logic              engRxPush,
  input  logic [DATA_W-1:0] engRxData,
  input  logic              hostRxPop,
  output logic [DATA_W-1:0] hostRxData,
  input  logic              hostTxPush,
  input  logic [DATA_W-1:0] hostTxData,
  input  logic              engTxPop,
  output logic [DATA_W-1:0] engTxData,
  output logic              rxEmpty,
  output logic              txFull,
  output logic              txNearEmpty,
  output logic              rxNearFull,
  output logic              rxOverflow,
  output logic              txOverflow,
  output logic              rxDmaReq,
  output logic              txDmaReq,
  output logic              irq
);

  strobe_t          strobe;
  logic [CNT_W-1:0] rxLevel, rxLevelNext, txLevel, txLevelNext;

  spiff_ctrl #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .TX_LO_BITS(TX_LO_BITS),
    .TX_HI_BITS(TX_HI_BITS), .RX_FULL_BITS(RX_FULL_BITS)
  ) ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .regWe       (regWe),
    .regWdata    (regWdata),
    .regRdata    (regRdata),
    .rxDmaEn     (rxDmaEn),
    .txDmaEn     (txDmaEn),
    .rxIntEn     (rxIntEn),
    .txIntEn     (txIntEn),
    .engRxPush   (engRxPush),
    .hostRxPop   (hostRxPop),
    .hostTxPush  (hostTxPush),
    .engTxPop    (engTxPop),
    .rxLevel     (rxLevel),
    .rxLevelNext (rxLevelNext),
    .txLevel     (txLevel),
    .txLevelNext (txLevelNext),
    .strobe      (strobe),
    .rxEmpty     (rxEmpty),
    .txFull      (txFull),
    .txNearEmpty (txNearEmpty),
    .rxNearFull  (rxNearFull),
    .rxOverflow  (rxOverflow),
    .txOverflow  (txOverflow),
    .rxDmaReq    (rxDmaReq),
    .txDmaReq    (txDmaReq),
    .irq         (irq)
  );

  spiff_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .engRxData   (engRxData),
    .hostRxData  (hostRxData),
    .hostTxData  (hostTxData),
    .engTxData   (engTxData),
    .rxLevel     (rxLevel),
    .rxLevelNext (rxLevelNext),
    .txLevel     (txLevel),
    .txLevelNext (txLevelNext)
  );

endmodule

// File: tb/spi_fifo_flags_test.sv
module spi_fifo_flags_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic rxDmaEn = 1'b0, txDmaEn = 1'b0, rxIntEn = 1'b0, txIntEn = 1'b0;
  logic engRxPush = 1'b0, hostRxPop = 1'b0, hostTxPush = 1'b0, engTxPop = 1'b0;
  logic [7:0] engRxData = '0, hostTxData = '0;
  logic [7:0] hostRxData, engTxData;
  logic rxEmpty, txFull, txNearEmpty, rxNearFull, rxOverflow, txOverflow;
  logic rxDmaReq, txDmaReq, irq;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  spi_fifo_flags uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .rxDmaEn(rxDmaEn), .txDmaEn(txDmaEn), .rxIntEn(rxIntEn), .txIntEn(txIntEn),
    .engRxPush(engRxPush), .engRxData(engRxData), .hostRxPop(hostRxPop),
    .hostRxData(hostRxData), .hostTxPush(hostTxPush), .hostTxData(hostTxData),
    .engTxPop(engTxPop), .engTxData(engTxData), .rxEmpty(rxEmpty), .txFull(txFull),
    .txNearEmpty(txNearEmpty), .rxNearFull(rxNearFull), .rxOverflow(rxOverflow),
    .txOverflow(txOverflow), .rxDmaReq(rxDmaReq), .txDmaReq(txDmaReq), .irq(irq)
  );

  // Reference model state
  logic [7:0] rxQ[$];
  logic [7:0] txQ[$];
  logic [3:0] mCtrl = '0;
  logic [7:0] mRxData = '0, mTxData = '0;
  logic mRxOvf = 0, mTxOvf = 0;
  logic eRxEmpty = 1, eTxFull = 0, eTxNear = 1, eRxNear = 0;
  logic eRxDma = 0, eTxDma = 0, eIrq = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic nearMark(input int lvl, input logic sel);
    return sel ? (lvl <= 4) : (lvl <= 2);
  endfunction

  task automatic checkAll();
    chk("R2 regRdata", 32'(regRdata), 32'({4'b0, mCtrl}));
    chk("R5 rxEmpty", 32'(rxEmpty), 32'(eRxEmpty));
    chk("R5 txFull", 32'(txFull), 32'(eTxFull));
    chk("R6 txNearEmpty", 32'(txNearEmpty), 32'(eTxNear));
    chk("R7 rxNearFull", 32'(rxNearFull), 32'(eRxNear));
    chk("R8 rxDmaReq", 32'(rxDmaReq), 32'(eRxDma));
    chk("R8 txDmaReq", 32'(txDmaReq), 32'(eTxDma));
    chk("R9 irq", 32'(irq), 32'(eIrq));
    chk("R11 rxOverflow", 32'(rxOverflow), 32'(mRxOvf));
    chk("R11 txOverflow", 32'(txOverflow), 32'(mTxOvf));
    chk("R4 hostRxData", 32'(hostRxData), 32'(mRxData));
    chk("R4 engTxData", 32'(engTxData), 32'(mTxData));
  endtask

  // Called at a falling edge; drives one cycle, updates model, checks.
  task automatic step(input logic rPush, input logic [7:0] rData, input logic rPop,
                      input logic tPush, input logic [7:0] tData, input logic tPop,
                      input logic we, input logic [7:0] wd);
    int preRx, preTx;
    engRxPush = rPush; engRxData = rData; hostRxPop = rPop;
    hostTxPush = tPush; hostTxData = tData; engTxPop = tPop;
    regWe = we; regWdata = wd;
    @(posedge clk);
    preRx = rxQ.size();
    preTx = txQ.size();
    if (mCtrl[0]) begin
      if (rPop) mRxData = (preRx > 0) ? rxQ.pop_front() : 8'h00;
      if (rPush) begin
        if (preRx < 8) rxQ.push_back(rData); else mRxOvf = 1;
      end
      if (tPop) mTxData = (preTx > 0) ? txQ.pop_front() : 8'h00;
      if (tPush) begin
        if (preTx < 8) txQ.push_back(tData); else mTxOvf = 1;
      end
    end
    eRxEmpty = rxQ.size() == 0;
    eTxFull  = txQ.size() == 8;
    eTxNear  = nearMark(txQ.size(), mCtrl[3]);
    eRxNear  = rxQ.size() >= 6;
    eRxDma   = mCtrl[0] && rxDmaEn && !eRxEmpty;
    eTxDma   = mCtrl[0] && txDmaEn && !eTxFull;
    eIrq     = mCtrl[0] && ((!rxDmaEn && rxIntEn && !eRxEmpty) ||
                            (!txDmaEn && txIntEn && !eTxFull) ||
                            (mCtrl[1] && eTxNear) || (mCtrl[2] && eRxNear));
    if (we && wd[0]) mCtrl = wd[3:0];
    @(negedge clk);
    checkAll();
  endtask

  task automatic idle();
    step(0, 8'h00, 0, 0, 8'h00, 0, 0, 8'h00);
  endtask

  task automatic wr(input logic [7:0] v);
    step(0, 8'h00, 0, 0, 8'h00, 0, 1, v);
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finishRun();
  end

  initial begin
    int seed;
    int bias;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 regRdata", 32'(regRdata), 32'h00);
    chk("R1 rxEmpty", 32'(rxEmpty), 32'h1);
    chk("R1 txFull", 32'(txFull), 32'h0);
    chk("R1 txNearEmpty", 32'(txNearEmpty), 32'h1);
    chk("R1 rxNearFull", 32'(rxNearFull), 32'h0);
    chk("R1 requests", 32'({rxDmaReq, txDmaReq, irq}), 32'h0);
    chk("R1 overflow", 32'({rxOverflow, txOverflow}), 32'h0);
    chk("R1 popData", 32'({hostRxData, engTxData}), 32'h0);

    // R3 disabled mode ignores traffic
    rxDmaEn = 1; txDmaEn = 1; rxIntEn = 1; txIntEn = 1;
    step(1, 8'h5A, 0, 1, 8'h6B, 0, 0, 8'h00);
    step(1, 8'h5B, 1, 1, 8'h6C, 1, 0, 8'h00);
    chk("R3 rxEmpty stays", 32'(rxEmpty), 32'h1);
    chk("R3 txNearEmpty stays", 32'(txNearEmpty), 32'h1);
    chk("R3 no requests", 32'({rxDmaReq, txDmaReq, irq}), 32'h0);
    chk("R3 pop data untouched", 32'(hostRxData), 32'h0);
    rxDmaEn = 0; txDmaEn = 0; rxIntEn = 0; txIntEn = 0;

    // R2 gated writes and reserved bits
    wr(8'h0E);
    chk("R2 write without enable ignored", 32'(regRdata), 32'h00);
    wr(8'hF1);
    chk("R2 reserved bits read zero", 32'(regRdata), 32'h01);

    // R4 ordering
    step(1, 8'hA1, 0, 0, 8'h00, 0, 0, 8'h00);
    step(1, 8'hB2, 0, 0, 8'h00, 0, 0, 8'h00);
    step(1, 8'hC3, 0, 0, 8'h00, 0, 0, 8'h00);
    step(0, 8'h00, 1, 0, 8'h00, 0, 0, 8'h00);
    chk("R4 first out", 32'(hostRxData), 32'hA1);
    step(0, 8'h00, 1, 0, 8'h00, 0, 0, 8'h00);
    chk("R4 second out", 32'(hostRxData), 32'hB2);
    step(0, 8'h00, 1, 0, 8'h00, 0, 0, 8'h00);
    chk("R4 third out", 32'(hostRxData), 32'hC3);
    chk("R5 empty after drain", 32'(rxEmpty), 32'h1);

    // R11 pop from empty returns zero
    step(0, 8'h00, 1, 0, 8'h00, 0, 0, 8'h00);
    chk("R11 empty pop gives zero", 32'(hostRxData), 32'h00);
    chk("R11 empty pop keeps level", 32'(rxEmpty), 32'h1);

    // R11 / R5 tx overflow
    for (int i = 0; i < 9; i++) step(0, 8'h00, 0, 1, 8'(8'h10 + i), 0, 0, 8'h00);
    chk("R5 txFull at eight", 32'(txFull), 32'h1);
    chk("R11 txOverflow sticky set", 32'(txOverflow), 32'h1);
    for (int i = 0; i < 5; i++) step(0, 8'h00, 0, 0, 8'h00, 1, 0, 8'h00);
    chk("R11 dropped byte never appears", 32'(engTxData), 32'h14);
    chk("R11 overflow holds", 32'(txOverflow), 32'h1);

    // R6 watermark selection: tx level now 3
    chk("R6 level3 sel0", 32'(txNearEmpty), 32'h0);
    wr(8'h09);
    idle();
    chk("R6 level3 sel1", 32'(txNearEmpty), 32'h1);
    step(0, 8'h00, 0, 1, 8'h77, 0, 0, 8'h00);
    step(0, 8'h00, 0, 1, 8'h78, 0, 0, 8'h00);
    chk("R6 level5 sel1", 32'(txNearEmpty), 32'h0);
    wr(8'h01);
    for (int i = 0; i < 3; i++) step(0, 8'h00, 0, 0, 8'h00, 1, 0, 8'h00);
    chk("R6 level2 sel0", 32'(txNearEmpty), 32'h1);

    // R7 rx watermark and R10 interrupt from it
    wr(8'h05);
    for (int i = 0; i < 5; i++) step(1, 8'(8'h40 + i), 0, 0, 8'h00, 0, 0, 8'h00);
    chk("R7 five bytes not near full", 32'(rxNearFull), 32'h0);
    chk("R10 no watermark irq yet", 32'(irq), 32'h0);
    step(1, 8'h45, 0, 0, 8'h00, 0, 0, 8'h00);
    chk("R7 six bytes near full", 32'(rxNearFull), 32'h1);
    chk("R10 rx watermark irq", 32'(irq), 32'h1);
    rxDmaEn = 1;
    idle();
    chk("R10 watermark irq ignores DMA enable", 32'(irq), 32'h1);
    chk("R8 rx DMA request", 32'(rxDmaReq), 32'h1);
    wr(8'h01);
    rxDmaEn = 0; rxIntEn = 1;
    idle();
    chk("R9 rx data interrupt", 32'(irq), 32'h1);
    rxDmaEn = 1;
    idle();
    chk("R9 DMA takes over rx", 32'(irq), 32'h0);
    rxDmaEn = 0; rxIntEn = 0;
    for (int i = 0; i < 6; i++) step(0, 8'h00, 1, 0, 8'h00, 0, 0, 8'h00);
    chk("R8 rx request drops when empty", 32'(rxDmaReq), 32'h0);

    // Random traffic with fill/drain bias phases
    bias = 50;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      logic we;
      logic [7:0] wd;
      if (cyc % 150 == 0) bias = 15 + ($urandom % 70);
      if ($urandom % 50 == 0) begin
        rxDmaEn = 1'($urandom); txDmaEn = 1'($urandom);
        rxIntEn = 1'($urandom); txIntEn = 1'($urandom);
      end
      we = ($urandom % 40) == 0;
      wd = 8'($urandom);
      if ($urandom % 3 != 0) wd[0] = 1'b1;
      step(($urandom % 100) < bias, 8'($urandom), ($urandom % 100) >= bias,
           ($urandom % 100) < bias, 8'($urandom), ($urandom % 100) >= bias,
           we, wd);
    end

    finishRun();
  end

endmodule